// File: doc/BRIEF.md
# Modem Control Line Driver and Status-Change Monitor

This block sits beside a synchronous serial channel. It drives two modem-control outputs: a request-to-send line and a terminal-ready line. Each output is the inverse of a control bit, so clearing a bit drives its line high. The block also watches two modem-status inputs, carrier detect and clear-to-send. Each input goes through a synchronizer and then a pulse-width filter. The minimum width is a programmable number of clock cycles. Each filtered level can act as an auto-enable that gates the receiver (carrier) or the transmitter (clear-to-send).

A filtered change on either input is called an accepted change. When one occurs, the block captures both filtered levels into a status field for the CPU to read. If status-change interrupts are enabled, it also sets a sticky interrupt flag. While the flag is set, the status field stays frozen. The CPU therefore reads the levels that caused the interrupt. A one-cycle clear strobe drops the flag.

Top module: `modem_ctl_mon`

## Requirements
- R1: After reset, `rts_out` and `dtr_out` are 1, `irq` is 0 and `stat_lines` is 00.
- R2: One cycle after a write with `ctl_we` high, `rts_out` equals the inverse of `ctl_wdata[0]` and `dtr_out` equals the inverse of `ctl_wdata[1]`. Without a write, both outputs hold their value.
- R3: A level on an input is accepted only after the synchronized input has differed from the filtered level on `min_width` consecutive cycles. A pulse that lasts fewer cycles is ignored. A `min_width` of 0 behaves like 1.
- R4: A level change applied between clock edges reaches `stat_lines` on the (`min_width`+2)th rising edge after it is applied, and not earlier. The count covers two synchronizer stages and then the filter.
- R5: `ctl_wdata[2]` enables status-change interrupts. When it is 1, an accepted change on either input sets `irq`. When it is 0, `irq` stays 0 and `stat_lines` follows the accepted levels.
- R6: While `irq` is 1, `stat_lines` does not change and `irq` stays 1, whatever the inputs do.
- R7: A one-cycle `irq_clr` pulse clears `irq` on the next edge. The next accepted change after that updates `stat_lines` and, if enabled, sets `irq` again.
- R8: `rx_run` = `rx_en_in` AND (NOT `ctl_wdata[3]` OR filtered carrier). `tx_run` = `tx_en_in` AND (NOT `ctl_wdata[4]` OR filtered clear-to-send). Here `ctl_wdata[3]` and `ctl_wdata[4]` are the values from the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control bits: [0] send request, [1] terminal ready, [2] interrupt enable, [3] receive auto-enable, [4] transmit auto-enable |
| pw_we | input | 1 | Minimum pulse width write strobe |
| pw_wdata | input | CNT_W | Minimum pulse width in clock cycles |
| carrier_in | input | 1 | Asynchronous carrier-detect input |
| cts_in | input | 1 | Asynchronous clear-to-send input |
| rx_en_in | input | 1 | Receiver enable request |
| tx_en_in | input | 1 | Transmitter enable request |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| rts_out | output | 1 | Request-to-send output (inverted control bit) |
| dtr_out | output | 1 | Terminal-ready output (inverted control bit) |
| rx_run | output | 1 | Gated receiver enable |
| tx_run | output | 1 | Gated transmitter enable |
| stat_lines | output | 2 | Captured levels: [0] carrier, [1] clear-to-send |
| irq | output | 1 | Sticky status-change interrupt |

## Verification
The bound assertions check on every cycle:
- the output lines follow each control write, inverted;
- the interrupt flag stays set until a clear strobe arrives;
- the captured status stays frozen while the flag is set;
- the run outputs never assert without their enable request.

Other behaviours depend on how long an input is held, so only the bench scenarios can show them:
- the filter's exact acceptance cycle;
- rejection of a pulse one cycle short of the minimum;
- the zero-width case;
- the update after a clear.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
    localparam int CTL_W    = 5;
    localparam int LINES    = 2;
    localparam int LINE_CAR = 0;
    localparam int LINE_CTS = 1;

    typedef struct packed {
        logic tx_auto;
        logic rx_auto;
        logic int_en;
        logic dtr;
        logic rts;
    } ctl_t;
endpackage

// File: rtl/mcm_sync.sv
module mcm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mcm_filter.sv
module mcm_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [CNT_W-1:0] min_width,
    output logic             level,
    output logic             accept
);
    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        flt_d   = flt_q;
        accept  = 1'b0;
        need    = (min_width == '0) ? CNT_W'(1) : min_width;
        cnt_inc = {1'b0, flt_q.cnt} + 1'b1;
        if (sample != flt_q.level) begin
            if (cnt_inc >= {1'b0, need}) begin
                flt_d.level = sample;
                flt_d.cnt   = '0;
                accept      = 1'b1;
            end else begin
                flt_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign level = flt_q.level;
endmodule

// File: rtl/modem_ctl_mon.sv
module modem_ctl_mon
    import mcm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PW_RESET    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [4:0]       ctl_wdata,
    input  logic             pw_we,
    input  logic [CNT_W-1:0] pw_wdata,
    input  logic             carrier_in,
    input  logic             cts_in,
    input  logic             rx_en_in,
    input  logic             tx_en_in,
    input  logic             irq_clr,
    output logic             rts_out,
    output logic             dtr_out,
    output logic             rx_run,
    output logic             tx_run,
    output logic [1:0]       stat_lines,
    output logic             irq
);
    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] pw;
        logic [LINES-1:0] stat;
        logic             irq;
    } st_t;

    st_t st_d, st_q;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] acc;

    assign raw[LINE_CAR] = carrier_in;
    assign raw[LINE_CTS] = cts_in;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        mcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw[i]),
            .q     (synced[i])
        );
        mcm_filter #(.CNT_W(CNT_W)) u_flt (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample    (synced[i]),
            .min_width (st_q.pw),
            .level     (lvl[i]),
            .accept    (acc[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (ctl_we) st_d.ctl = ctl_t'(ctl_wdata[CTL_W-1:0]);
        if (pw_we)  st_d.pw  = pw_wdata;
        if ((|acc) && (!st_q.irq || irq_clr)) st_d.stat = lvl ^ acc;
        st_d.irq = (st_q.irq & ~irq_clr) | ((|acc) & st_q.ctl.int_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pw   <= CNT_W'(PW_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_out    = ~st_q.ctl.rts;
    assign dtr_out    = ~st_q.ctl.dtr;
    assign rx_run     = rx_en_in & (~st_q.ctl.rx_auto | lvl[LINE_CAR]);
    assign tx_run     = tx_en_in & (~st_q.ctl.tx_auto | lvl[LINE_CTS]);
    assign stat_lines = st_q.stat;
    assign irq        = st_q.irq;
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [4:0] ctl_wdata,
    input logic       irq_clr,
    input logic       irq,
    input logic [1:0] stat_lines,
    input logic       rts_out,
    input logic       dtr_out,
    input logic       rx_run,
    input logic       rx_en_in,
    input logic       tx_run,
    input logic       tx_en_in
);
    // R2
    rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (rts_out == !$past(ctl_wdata[0])));
    // R2
    dtr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (dtr_out == !$past(ctl_wdata[1])));
    // R2
    lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> ($stable(rts_out) && $stable(dtr_out)));
    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    // R6
    stat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> $stable(stat_lines));
    // R8
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_run |-> rx_en_in);
    // R8
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_run |-> tx_en_in);
endmodule

bind modem_ctl_mon mcm_checker u_mcm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .irq_clr    (irq_clr),
    .irq        (irq),
    .stat_lines (stat_lines),
    .rts_out    (rts_out),
    .dtr_out    (dtr_out),
    .rx_run     (rx_run),
    .rx_en_in   (rx_en_in),
    .tx_run     (tx_run),
    .tx_en_in   (tx_en_in)
);

// File: tb/test_modem_ctl_mon.sv
`timescale 1ns/1ps
module test_modem_ctl_mon;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we = 1'b0;
    logic [4:0]       ctl_wdata = '0;
    logic             pw_we = 1'b0;
    logic [CNT_W-1:0] pw_wdata = '0;
    logic             carrier_in = 1'b0;
    logic             cts_in = 1'b0;
    logic             rx_en_in = 1'b0;
    logic             tx_en_in = 1'b0;
    logic             irq_clr = 1'b0;
    logic             rts_out, dtr_out, rx_run, tx_run, irq;
    logic [1:0]       stat_lines;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    modem_ctl_mon #(.CNT_W(CNT_W)) i_modem_ctl_mon (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .pw_we(pw_we), .pw_wdata(pw_wdata), .carrier_in(carrier_in),
        .cts_in(cts_in), .rx_en_in(rx_en_in), .tx_en_in(tx_en_in),
        .irq_clr(irq_clr), .rts_out(rts_out), .dtr_out(dtr_out),
        .rx_run(rx_run), .tx_run(tx_run), .stat_lines(stat_lines), .irq(irq)
    );

    // {ctl[4:0], carrier, cts, rx_en, tx_en, exp_rx, exp_tx, exp_rts, exp_dtr}
    localparam logic [12:0] VEC [8] = '{
        13'b00000_0011_1111,
        13'b01000_0011_0111,
        13'b01000_1011_1111,
        13'b10000_1011_1011,
        13'b11011_1111_1100,
        13'b11001_0110_0001,
        13'b00010_0001_0110,
        13'b11000_1100_0011
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctl(input logic [4:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic write_pw(input logic [CNT_W-1:0] v);
        @(negedge clk); pw_we = 1'b1; pw_wdata = v;
        @(negedge clk); pw_we = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        carrier_in = 1'b0; cts_in = 1'b0; rx_en_in = 1'b0; tx_en_in = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check(rts_out == 1'b1, "R1 rts_out", rts_out, 1);
        check(dtr_out == 1'b1, "R1 dtr_out", dtr_out, 1);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(stat_lines == 2'b00, "R1 stat_lines", stat_lines, 0);

        write_pw(8'd3);
        write_ctl(5'b00100);

        // R3: pulse of pw-1 cycles is ignored
        @(negedge clk); carrier_in = 1'b1;
        cycles(2); carrier_in = 1'b0;
        cycles(10);
        check(irq == 1'b0, "R3 short pulse irq", irq, 0);
        check(stat_lines == 2'b00, "R3 short pulse stat", stat_lines, 0);

        // R4: acceptance edge is pw+2 after the change
        carrier_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(stat_lines == 2'b00, "R4 before edge pw+2", stat_lines, 0);
        @(posedge clk); @(negedge clk);
        check(stat_lines == 2'b01, "R4 at edge pw+2", stat_lines, 1);
        check(irq == 1'b1, "R5 irq on carrier change", irq, 1);

        // R6: frozen while flag set
        carrier_in = 1'b0; cts_in = 1'b1;
        cycles(10);
        check(stat_lines == 2'b01, "R6 stat frozen", stat_lines, 1);
        check(irq == 1'b1, "R6 irq held", irq, 1);

        // R7: clear, then next accepted change updates
        pulse_clr();
        check(irq == 1'b0, "R7 irq cleared", irq, 0);
        cts_in = 1'b0;
        cycles(10);
        check(stat_lines == 2'b00, "R7 stat after clear", stat_lines, 0);
        check(irq == 1'b1, "R5 irq on cts change", irq, 1);
        pulse_clr();

        // R5: disabled interrupt, status follows
        write_ctl(5'b00000);
        carrier_in = 1'b1;
        cycles(10);
        check(irq == 1'b0, "R5 irq disabled", irq, 0);
        check(stat_lines == 2'b01, "R5 stat follows", stat_lines, 1);

        // R3: zero width acts as one (accept on third edge)
        write_pw(8'd0);
        carrier_in = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(stat_lines == 2'b01, "R3 zero width before", stat_lines, 1);
        @(posedge clk); @(negedge clk);
        check(stat_lines == 2'b00, "R3 zero width accept", stat_lines, 0);

        // R8 / R2 vector table
        for (int k = 0; k < 8; k++) begin
            write_ctl(VEC[k][12:8]);
            carrier_in = VEC[k][7];
            cts_in     = VEC[k][6];
            rx_en_in   = VEC[k][5];
            tx_en_in   = VEC[k][4];
            cycles(8);
            check(rx_run == VEC[k][3], "R8 rx_run", rx_run, VEC[k][3]);
            check(tx_run == VEC[k][2], "R8 tx_run", tx_run, VEC[k][2]);
            check(rts_out == VEC[k][1], "R2 rts_out", rts_out, VEC[k][1]);
            check(dtr_out == VEC[k][0], "R2 dtr_out", dtr_out, VEC[k][0]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule